// File: doc/BRIEF.md
# Bit-Serial Ternary Content-Addressable Memory

This block stores a set of ternary words and searches them all against a key. A stored bit is 0, 1 or "either". Instead of comparing whole words in one cycle, the block walks the key one bit position at a time, starting at bit 0 and ending at bit WIDTH-1. Each bit step takes two cycles: a precharge cycle and then an evaluate cycle. Every word has an accumulator that holds its running match status. A word that has mismatched on some bit is dropped from evaluation for every later bit. This stands in for switching off that word's cells and sense logic, and the per-word enable vector makes the drop visible.

Software or a neighbouring block loads a word through the write port by giving an address, a value and a care mask. It then starts a search with a key and waits for the one-cycle done strobe. The full per-word match vector comes out, along with the lowest-numbered matching word and a flag that says whether any word matched. A busy search holds off both writes and new starts through the ready output.

Top module: `bst_cam`

## Requirements
- R1: A stored bit whose care bit is 0 matches either key bit. A stored bit whose care bit is 1 matches only a key bit equal to its value. Inside the block a bit is kept as a two-bit code: (0,0) means either, (1,0) means stored 0 and (0,1) means stored 1. The code (1,1) never matches.
- R2: The key is evaluated one bit per step, from bit 0 up to bit WIDTH-1. Each step is one precharge cycle followed by one evaluate cycle. done is high in the cycle that follows the 2*WIDTH-th rising edge after the edge that accepted srch_start.
- R3: When a search is accepted, every written word starts matching and active. A word never written since reset is neither active nor matching.
- R4: A word that mismatches on key bit k drops out of word_active after the evaluate cycle of bit k. It stays inactive and non-matching for the rest of that search. word_active is all zero outside a search.
- R5: done is a single-cycle pulse. match_vec holds the final result from the done cycle until the next accepted search.
- R6: hit_index is the lowest index set in match_vec, and hit_valid is high whenever any bit of match_vec is set. When no word matches, hit_valid is 0 and hit_index is 0.
- R7: ready is low from the edge that accepts a search until the done cycle has ended. A write or a srch_start presented while ready is low is ignored: no stored word changes and the running search is not restarted.
- R8: A write with ready high stores value and care at wr_addr and replaces any earlier content. Searches started later see the new word.
- R9: After reset, ready is 1, done is 0, match_vec and word_active are 0, hit_valid is 0, and no word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, taken when ready is high |
| wr_addr | input | $clog2(DEPTH) | Word address to write |
| wr_value | input | WIDTH | Bit values of the word |
| wr_care | input | WIDTH | Care mask, 0 marks a bit as either |
| ready | output | 1 | High when idle and able to take a write or a search |
| srch_start | input | 1 | Search request, taken when ready is high |
| srch_key | input | WIDTH | Search key, captured at the accepting edge |
| done | output | 1 | One-cycle pulse when the result is final |
| match_vec | output | DEPTH | Per-word match result |
| word_active | output | DEPTH | Per-word enable, low once a word has mismatched |
| hit_valid | output | 1 | At least one word matches |
| hit_index | output | $clog2(DEPTH) | Lowest matching word index |

## Verification
The bench checks word_active after every evaluate step against a prefix match computed from the key. This catches a design that walks the bits from the wrong end, keeps evaluating a word after it has failed, or re-enables a failed word. It times done to the exact cycle, which exposes a missing precharge cycle or a step too many. It checks that several matching words report the lowest index and that a word never written stays out of the result, even when the key would match its unwritten content. It sends a write and a second start into a running search, then searches again. A design that let either through would show a changed stored word, or a done at a shifted time with a different result.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef struct packed {
        logic b1;
        logic b2;
    } tcode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_EVAL,
        ST_DONE
    } seq_state_t;

    function automatic tcode_t tc_encode(input logic value, input logic care);
        tcode_t c;
        c.b1 = care & ~value;
        c.b2 = care & value;
        return c;
    endfunction

    function automatic logic tc_match(input tcode_t c, input logic key_bit);
        logic m;
        case ({c.b1, c.b2})
            2'b00:   m = 1'b1;
            2'b10:   m = ~key_bit;
            2'b01:   m = key_bit;
            default: m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tcam_seq.sv
module tcam_seq
    import tcam_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          ready,
    output logic          load,
    output logic          eval_en,
    output logic          running,
    output logic          done,
    output logic [IW-1:0] bit_idx
);

    localparam logic [IW-1:0] LAST_BIT = IW'(WIDTH - 1);

    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_PRE;
                        bit_idx <= '0;
                    end
                end
                ST_PRE:  state <= ST_EVAL;
                ST_EVAL: begin
                    if (bit_idx == LAST_BIT) begin
                        state <= ST_DONE;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        state   <= ST_PRE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ready   = (state == ST_IDLE);
        load    = ready & start;
        eval_en = (state == ST_EVAL);
        running = (state == ST_PRE) | (state == ST_EVAL);
        done    = (state == ST_DONE);
    end

endmodule

// File: rtl/tcam_word.sv
module tcam_word
    import tcam_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_value,
    input  logic [WIDTH-1:0] wr_care,
    input  logic             load,
    input  logic             eval_en,
    input  logic             running,
    input  logic [IW-1:0]    bit_idx,
    input  logic             key_bit,
    output logic             match,
    output logic             active
);

    tcode_t cells [WIDTH];
    logic   valid;
    logic   acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            for (int b = 0; b < WIDTH; b++) begin
                cells[b] <= '0;
            end
        end else if (wr_en) begin
            valid <= 1'b1;
            for (int b = 0; b < WIDTH; b++) begin
                cells[b] <= tc_encode(wr_value[b], wr_care[b]);
            end
        end
    end

    // Accumulator: only an enabled word is evaluated; a failed word sleeps.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= 1'b0;
        end else if (load) begin
            acc <= valid;
        end else if (eval_en && acc) begin
            acc <= tc_match(cells[bit_idx], key_bit);
        end
    end

    assign match  = acc;
    assign active = acc & running;

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vec,
    output logic             any,
    output logic [AW-1:0]    idx
);

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = AW'(i);
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/bst_cam.sv
module bst_cam
    import tcam_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_value,
    input  logic [WIDTH-1:0] wr_care,
    output logic             ready,
    input  logic             srch_start,
    input  logic [WIDTH-1:0] srch_key,
    output logic             done,
    output logic [DEPTH-1:0] match_vec,
    output logic [DEPTH-1:0] word_active,
    output logic             hit_valid,
    output logic [AW-1:0]    hit_index
);

    logic          load;
    logic          eval_en;
    logic          running;
    logic [IW-1:0] bit_idx;
    logic [WIDTH-1:0] key_q;
    logic          key_bit;

    tcam_seq #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (srch_start),
        .ready   (ready),
        .load    (load),
        .eval_en (eval_en),
        .running (running),
        .done    (done),
        .bit_idx (bit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (load) begin
            key_q <= srch_key;
        end
    end

    assign key_bit = key_q[bit_idx];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic sel;
        assign sel = wr_en & ready & (wr_addr == AW'(w));

        tcam_word #(.WIDTH(WIDTH)) u_word (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (sel),
            .wr_value (wr_value),
            .wr_care  (wr_care),
            .load     (load),
            .eval_en  (eval_en),
            .running  (running),
            .bit_idx  (bit_idx),
            .key_bit  (key_bit),
            .match    (match_vec[w]),
            .active   (word_active[w])
        );
    end

    tcam_prio #(.DEPTH(DEPTH)) u_prio (
        .vec (match_vec),
        .any (hit_valid),
        .idx (hit_index)
    );

endmodule

// File: rtl/tcam_chk.sv
module tcam_chk #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             ready,
    input logic             done,
    input logic             srch_start,
    input logic [DEPTH-1:0] match_vec,
    input logic [DEPTH-1:0] word_active,
    input logic             hit_valid,
    input logic [AW-1:0]    hit_index
);

    logic [DEPTH-1:0] below;
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            below[i] = (AW'(i) < hit_index);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> !ready); // R7

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ready && srch_start) |=> !ready); // R7

    AST_ACTIVE_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready)) |-> ((word_active & ~$past(word_active)) == '0)); // R4

    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        ready |-> (word_active == '0)); // R4

    AST_HIT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> (match_vec[hit_index] && ((match_vec & below) == '0))); // R6

    AST_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> (match_vec == '0 && hit_index == '0)); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready) && !$past(srch_start)) |-> $stable(match_vec)); // R5

endmodule

bind bst_cam tcam_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ready       (ready),
    .done        (done),
    .srch_start  (srch_start),
    .match_vec   (match_vec),
    .word_active (word_active),
    .hit_valid   (hit_valid),
    .hit_index   (hit_index)
);

// File: tb/bst_cam_test.sv
module bst_cam_test;

    localparam int W  = 8;
    localparam int D  = 8;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_value = '0;
    logic [W-1:0]  wr_care = '0;
    logic          ready;
    logic          srch_start = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic          done;
    logic [D-1:0]  match_vec;
    logic [D-1:0]  word_active;
    logic          hit_valid;
    logic [AW-1:0] hit_index;

    bst_cam #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_value(wr_value), .wr_care(wr_care), .ready(ready),
        .srch_start(srch_start), .srch_key(srch_key), .done(done),
        .match_vec(match_vec), .word_active(word_active),
        .hit_valid(hit_valid), .hit_index(hit_index)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_val   [D];
    logic [W-1:0] m_care  [D];
    logic         m_valid [D];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [D-1:0] prefix_vec(input logic [W-1:0] key, input int k);
        logic [D-1:0] v;
        for (int w = 0; w < D; w++) begin
            v[w] = m_valid[w];
            for (int b = 0; b < k; b++) begin
                if (m_care[w][b] && (m_val[w][b] != key[b])) v[w] = 1'b0;
            end
        end
        return v;
    endfunction

    function automatic logic [AW-1:0] low_idx(input logic [D-1:0] v);
        logic [AW-1:0] r = '0;
        for (int i = D - 1; i >= 0; i--) if (v[i]) r = AW'(i);
        return r;
    endfunction

    task automatic write_word(input int addr, input logic [W-1:0] val, input logic [W-1:0] care);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_value = val; wr_care = care;
        @(negedge clk);
        wr_en = 1'b0;
        m_val[addr] = val; m_care[addr] = care; m_valid[addr] = 1'b1;
    endtask

    // inj: 0 none, 1 write during busy, 2 second start during busy
    task automatic run_search(input string tag, input logic [W-1:0] key, input int inj,
                              input int iaddr, input logic [W-1:0] ival);
        logic [D-1:0] fin;
        @(negedge clk);
        srch_key = key; srch_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        srch_start = 1'b0;
        srch_key = ~key;
        fin = prefix_vec(key, W);
        for (int n = 0; n <= 2 * W + 1; n++) begin
            check("R2", {tag, " done timing"}, 32'(done), 32'(n == 2 * W));
            if ((n % 2 == 0) && (n / 2 < W))
                check((n == 0) ? "R3" : "R4", {tag, " word_active"},
                      32'(word_active), 32'(prefix_vec(key, n / 2)));
            if (n == 3) begin
                check("R7", {tag, " ready busy"}, 32'(ready), 32'h0);
                if (inj == 1) begin
                    wr_en = 1'b1; wr_addr = AW'(iaddr); wr_value = ival; wr_care = '1;
                end else if (inj == 2) begin
                    srch_key = ival; srch_start = 1'b1;
                end
            end
            if (n == 4) begin
                wr_en = 1'b0; srch_start = 1'b0;
            end
            if (n == 2 * W) begin
                check("R1", {tag, " match_vec"}, 32'(match_vec), 32'(fin));
                check("R6", {tag, " hit_valid"}, 32'(hit_valid), 32'(fin != '0));
                check("R6", {tag, " hit_index"}, 32'(hit_index), 32'(low_idx(fin)));
            end
            if (n == 2 * W + 1) begin
                check("R7", {tag, " ready after"}, 32'(ready), 32'h1);
                check("R4", {tag, " idle inactive"}, 32'(word_active), 32'h0);
                check("R5", {tag, " result held"}, 32'(match_vec), 32'(fin));
            end
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        check("R9", "reset ready", 32'(ready), 32'h1);
        check("R9", "reset done", 32'(done), 32'h0);
        check("R9", "reset match_vec", 32'(match_vec), 32'h0);
        check("R9", "reset active", 32'(word_active), 32'h0);
        check("R9", "reset hit_valid", 32'(hit_valid), 32'h0);
    endtask

    task automatic test_empty();
        run_search("R3 empty", 8'h00, 0, 0, '0);
    endtask

    task automatic test_exact();
        write_word(0, 8'h3C, 8'hFF);
        write_word(1, 8'hA5, 8'hFF);
        write_word(2, 8'h5A, 8'hFF);
        write_word(3, 8'h81, 8'hFF);
        run_search("R1 exact", 8'h5A, 0, 0, '0);
        check("R1", "exact single hit", 32'(hit_index), 32'h2);
    endtask

    task automatic test_dontcare();
        write_word(4, 8'h0A, 8'h0F);
        write_word(6, 8'h00, 8'h00);
        run_search("R1 dontcare", 8'hFA, 0, 0, '0);
        check("R1", "dontcare vec", 32'(match_vec), 32'h50);
        run_search("R6 multi", 8'h3C, 0, 0, '0);
        check("R6", "lowest of multi", 32'(hit_index), 32'h0);
    endtask

    task automatic test_nomatch();
        write_word(6, 8'h77, 8'hFF);
        run_search("R6 none", 8'hEE, 0, 0, '0);
        check("R6", "none valid", 32'(hit_valid), 32'h0);
        check("R6", "none index", 32'(hit_index), 32'h0);
    endtask

    task automatic test_gate_late();
        run_search("R4 late", 8'hD1, 0, 0, '0);
        run_search("R2 order", 8'h01, 0, 0, '0);
    endtask

    task automatic test_busy_write();
        run_search("R7 busy write", 8'h3C, 1, 0, 8'h99);
        run_search("R7 after write", 8'h99, 0, 0, '0);
        check("R7", "ignored write word0", 32'(match_vec[0]), 32'h0);
    endtask

    task automatic test_busy_start();
        run_search("R7 busy start", 8'hA5, 2, 0, 8'h81);
        check("R7", "restart ignored", 32'(hit_index), 32'h1);
    endtask

    task automatic test_hold();
        logic [D-1:0] v;
        v = match_vec;
        for (int i = 0; i < 5; i++) begin
            srch_key = W'(i * 37);
            @(negedge clk);
        end
        check("R5", "idle hold", 32'(match_vec), 32'(v));
    endtask

    task automatic test_overwrite();
        write_word(1, 8'h99, 8'hF0);
        run_search("R8 overwrite", 8'h95, 0, 0, '0);
        check("R8", "overwrite hit", 32'(match_vec[1]), 32'h1);
        run_search("R8 old gone", 8'hA5, 0, 0, '0);
        check("R8", "old content", 32'(match_vec[1]), 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int w = 0; w < D; w++) begin
            m_val[w] = '0; m_care[w] = '0; m_valid[w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_empty();
        test_exact();
        test_dontcare();
        test_nomatch();
        test_gate_late();
        test_busy_write();
        test_busy_start();
        test_hold();
        test_overwrite();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule